// File: doc/BRIEF.md
# DMX512 Packet Serializer

This block produces one full lighting-control packet on a single serial line each time it accepts a start pulse. It first pulls the line low for a break, then holds it high for a short mark. After that it sends a run of asynchronous characters back-to-back. The first 32 characters are read in index order from an external byte buffer. The rest are zero-valued padding characters: a number set by the configured slot count, followed by a fixed tail of 255. While the break and the mark are on the line, the character serializer is idle and the line level is driven directly.

The surrounding logic fills the buffer, sets the slot count and pulses start. The block reads the buffer through a plain address/data port and expects combinational read data. It reports `busy` while a packet is in progress and pulses `done` once the packet ends. Bit rate, break and mark lengths come from parameters that are scaled to the system clock frequency.

Top module: `dmx_frame_tx`

## Requirements
- R1: While no packet is active, including after reset, `line_o` is 1 and `busy_o` and `done_o` are 0.
- R2: A start pulse that is sampled at a clock edge while idle makes `busy_o` 1 and `line_o` 0 from that edge. The line stays low for exactly BREAK_US × CLK_HZ/10^6 cycles (176 at CLK_HZ = 2 MHz).
- R3: Right after the break, `line_o` is 1 for exactly MAB_US × CLK_HZ/10^6 cycles (16 at 2 MHz).
- R4: Every character takes 11 bit times of CLK_HZ/BAUD cycles each, in this order: one start bit at 0, eight data bits least-significant first, and two stop bits at 1. Characters follow each other with no idle gap.
- R5: Characters 0 to 31 carry buffer entries 0 to 31 in that order. `buf_raddr_o` addresses the entry and `buf_rdata_i` must be valid combinationally for that address.
- R6: With an effective slot count N, the packet holds 32 + (258 − N) + 255 characters. Every character after the 32nd is 0x00.
- R7: The slot count is sampled only in the cycle the start is accepted. Later changes to `slot_cnt_i` do not change the packet in progress.
- R8: A slot count above 258 is handled as 258.
- R9: A start pulse that arrives while `busy_o` is 1 has no effect. The packet in progress continues unchanged and no new packet follows.
- R10: The cycle after the last stop bit ends, `done_o` is 1 for exactly one cycle. In that same cycle `busy_o` is 0 and `line_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Packet start request, one cycle |
| slot_cnt_i | input | $clog2(PAD_BASE+1) | Configured slot count, sampled at an accepted start |
| buf_raddr_o | output | $clog2(BUF_SLOTS) | Slot buffer read address |
| buf_rdata_i | input | 8 | Slot buffer read data, combinational for the address |
| line_o | output | 1 | Serial output line |
| busy_o | output | 1 | Packet in progress |
| done_o | output | 1 | One-cycle pulse at packet end |

## Verification
Every output is driven from registers, so a start that is accepted at edge k shows up on the line from edge k. The break covers the first BRK cycles, the mark the next MAB cycles, and character c, bit b covers the BIT_DIV cycles that begin (BRK + MAB + (11c + b)·BIT_DIV) cycles after edge k. `done_o` follows one cycle after the final bit time. The bench drives start at a falling edge and then samples line, busy and done at each later falling edge. It compares every sample with the value it computes for that cycle index, so any extra or missing cycle shifts the stream and is reported. Packets at slot counts 258, 0, 300 and 257 cover the padding arithmetic, the clamp and the sampling rule. Start pulses injected during the break and in the middle of data check that a busy block ignores them.

// File: rtl/dmx_tx_pkg.sv
package dmx_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BREAK = 2'd1,
    ST_MAB   = 2'd2,
    ST_DATA  = 2'd3
  } seq_st_t;

  localparam int unsigned DATA_BITS = 8;
endpackage

// File: rtl/dmx_bit_timer.sv
module dmx_bit_timer #(
  parameter int unsigned DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DW-1:0] cnt_q, cnt_d;

  assign tick_o = en_i && (cnt_q == DW'(DIV - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)
      cnt_d = '0;
    else if (en_i)
      cnt_d = tick_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dmx_char_ser.sv
module dmx_char_ser #(
  parameter int unsigned STOP_BITS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic [7:0] data_i,
  input  logic       tick_i,
  output logic       txd_o,
  output logic       active_o,
  output logic       char_end_o
);
  localparam int unsigned CHAR_BITS = 1 + dmx_tx_pkg::DATA_BITS + STOP_BITS;
  localparam int unsigned BW        = $clog2(CHAR_BITS);

  logic [CHAR_BITS-1:0] sh_q, sh_d;
  logic [BW-1:0]        left_q, left_d;
  logic                 act_q, act_d;

  assign char_end_o = act_q && tick_i && (left_q == '0);
  assign txd_o      = act_q ? sh_q[0] : 1'b1;
  assign active_o   = act_q;

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    act_d  = act_q;
    if (load_i) begin
      sh_d   = {{STOP_BITS{1'b1}}, data_i, 1'b0};
      left_d = BW'(CHAR_BITS - 1);
      act_d  = 1'b1;
    end else if (act_q && tick_i) begin
      if (left_q == '0) begin
        act_d = 1'b0;
      end else begin
        sh_d   = {1'b1, sh_q[CHAR_BITS-1:1]};
        left_d = left_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      left_q <= '0;
      act_q  <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      left_q <= left_d;
      act_q  <= act_d;
    end
  end
endmodule

// File: rtl/dmx_pkt_seq.sv
module dmx_pkt_seq
  import dmx_tx_pkg::*;
#(
  parameter int unsigned BRK_CYC    = 176,
  parameter int unsigned MAB_CYC    = 16,
  parameter int unsigned BUF_SLOTS  = 32,
  parameter int unsigned PAD_BASE   = 258,
  parameter int unsigned TAIL_ZEROS = 255,
  parameter int unsigned SW         = 9,
  parameter int unsigned AW         = 5,
  parameter int unsigned CW         = 10,
  parameter int unsigned IVW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [SW-1:0] slot_cnt_i,
  input  logic          char_end_i,
  output logic          load_o,
  output logic          in_buf_o,
  output logic [AW-1:0] buf_raddr_o,
  output seq_st_t       st_o,
  output logic          done_o
);
  localparam int unsigned MAX_CHARS = BUF_SLOTS + PAD_BASE + TAIL_ZEROS;

  seq_st_t        st_q, st_d;
  logic [IVW-1:0] ivl_q, ivl_d;
  logic [CW-1:0]  cidx_q, cidx_d;
  logic [CW-1:0]  tot_q, tot_d;
  logic           done_q, done_d;
  logic           ivl_zero, last_end;
  logic [SW-1:0]  eff_slots;

  assign ivl_zero  = (ivl_q == '0);
  assign eff_slots = (slot_cnt_i > SW'(PAD_BASE)) ? SW'(PAD_BASE) : slot_cnt_i;
  assign last_end  = (st_q == ST_DATA) && char_end_i && (cidx_q == tot_q);
  assign load_o    = ((st_q == ST_MAB) && ivl_zero) ||
                     ((st_q == ST_DATA) && char_end_i && (cidx_q != tot_q));
  assign in_buf_o    = (cidx_q < CW'(BUF_SLOTS));
  assign buf_raddr_o = in_buf_o ? cidx_q[AW-1:0] : '0;
  assign st_o        = st_q;
  assign done_o      = done_q;

  always_comb begin
    st_d   = st_q;
    ivl_d  = ivl_q;
    cidx_d = cidx_q;
    tot_d  = tot_q;
    done_d = last_end;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d   = ST_BREAK;
          ivl_d  = IVW'(BRK_CYC - 1);
          cidx_d = '0;
          tot_d  = CW'(MAX_CHARS) - CW'(eff_slots);
        end
      end
      ST_BREAK: begin
        if (ivl_zero) begin
          st_d  = ST_MAB;
          ivl_d = IVW'(MAB_CYC - 1);
        end else begin
          ivl_d = ivl_q - 1'b1;
        end
      end
      ST_MAB: begin
        if (ivl_zero) st_d  = ST_DATA;
        else          ivl_d = ivl_q - 1'b1;
      end
      ST_DATA: begin
        if (last_end) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
    if (load_o) cidx_d = cidx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ivl_q  <= '0;
      cidx_q <= '0;
      tot_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ivl_q  <= ivl_d;
      cidx_q <= cidx_d;
      tot_q  <= tot_d;
      done_q <= done_d;
    end
  end
endmodule

// File: rtl/dmx_frame_tx.sv
module dmx_frame_tx
  import dmx_tx_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 250_000_000,
  parameter int unsigned BAUD       = 250_000,
  parameter int unsigned BREAK_US   = 88,
  parameter int unsigned MAB_US     = 8,
  parameter int unsigned STOP_BITS  = 2,
  parameter int unsigned BUF_SLOTS  = 32,
  parameter int unsigned PAD_BASE   = 258,
  parameter int unsigned TAIL_ZEROS = 255
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start_i,
  input  logic [$clog2(PAD_BASE+1)-1:0]  slot_cnt_i,
  output logic [$clog2(BUF_SLOTS)-1:0]   buf_raddr_o,
  input  logic [7:0]                     buf_rdata_i,
  output logic                           line_o,
  output logic                           busy_o,
  output logic                           done_o
);
  localparam int unsigned BIT_DIV    = CLK_HZ / BAUD;
  localparam int unsigned CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int unsigned BRK_CYC    = BREAK_US * CYC_PER_US;
  localparam int unsigned MAB_CYC    = MAB_US * CYC_PER_US;
  localparam int unsigned MAX_CHARS  = BUF_SLOTS + PAD_BASE + TAIL_ZEROS;
  localparam int unsigned CW         = $clog2(MAX_CHARS + 1);
  localparam int unsigned SW         = $clog2(PAD_BASE + 1);
  localparam int unsigned AW         = $clog2(BUF_SLOTS);
  localparam int unsigned IV_MAX     = (BRK_CYC > MAB_CYC) ? BRK_CYC : MAB_CYC;
  localparam int unsigned IVW        = $clog2(IV_MAX + 1);

  // reset synchronizer: asserts at once, releases on the clock
  logic rst_meta_q, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  seq_st_t    st;
  logic       load, in_buf, tick, txd, ser_act, char_end;
  logic [7:0] ser_data;

  dmx_pkt_seq #(
    .BRK_CYC   (BRK_CYC),
    .MAB_CYC   (MAB_CYC),
    .BUF_SLOTS (BUF_SLOTS),
    .PAD_BASE  (PAD_BASE),
    .TAIL_ZEROS(TAIL_ZEROS),
    .SW        (SW),
    .AW        (AW),
    .CW        (CW),
    .IVW       (IVW)
  ) seq_i (
    .clk        (clk),
    .rst_n      (rst_q),
    .start_i    (start_i),
    .slot_cnt_i (slot_cnt_i),
    .char_end_i (char_end),
    .load_o     (load),
    .in_buf_o   (in_buf),
    .buf_raddr_o(buf_raddr_o),
    .st_o       (st),
    .done_o     (done_o)
  );

  assign ser_data = in_buf ? buf_rdata_i : 8'h00;

  dmx_bit_timer #(.DIV(BIT_DIV)) tmr_i (
    .clk   (clk),
    .rst_n (rst_q),
    .clr_i (load),
    .en_i  (ser_act),
    .tick_o(tick)
  );

  dmx_char_ser #(.STOP_BITS(STOP_BITS)) ser_i (
    .clk       (clk),
    .rst_n     (rst_q),
    .load_i    (load),
    .data_i    (ser_data),
    .tick_i    (tick),
    .txd_o     (txd),
    .active_o  (ser_act),
    .char_end_o(char_end)
  );

  always_comb begin
    unique case (st)
      ST_BREAK: line_o = 1'b0;
      ST_DATA:  line_o = txd;
      default:  line_o = 1'b1;
    endcase
  end

  assign busy_o = (st != ST_IDLE);
endmodule

// File: rtl/dmx_frame_tx_chk.sv
module dmx_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic line_o,
  input logic busy_o,
  input logic done_o
);
  // R1
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> line_o);

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && !line_o));

  // R4
  stop_before_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(line_o));

  // R9
  busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (busy_o || done_o));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && line_o));
endmodule

bind dmx_frame_tx dmx_frame_tx_chk chk_i (
  .clk    (clk),
  .rst_n  (rst_q),
  .start_i(start_i),
  .line_o (line_o),
  .busy_o (busy_o),
  .done_o (done_o)
);

// File: tb/dmx_frame_tx_tb_top.sv
module dmx_frame_tx_tb_top;
  localparam int unsigned TB_CLK_HZ = 2_000_000;
  localparam int unsigned TB_BIT    = TB_CLK_HZ / 250_000;
  localparam int unsigned TB_BRK    = 88 * (TB_CLK_HZ / 1_000_000);
  localparam int unsigned TB_MAB    = 8 * (TB_CLK_HZ / 1_000_000);

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic [8:0] slot_cnt_i;
  logic [4:0] buf_raddr_o;
  logic [7:0] buf_rdata_i;
  logic       line_o, busy_o, done_o;
  logic [7:0] seed_q;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  int idx;
  int pulse_a, pulse_b;

  always #2 clk = ~clk;

  function automatic logic [7:0] pat(input int a, input logic [7:0] s);
    return 8'((a * 37) + s);
  endfunction

  assign buf_rdata_i = pat(int'(buf_raddr_o), seed_q);

  dmx_frame_tx #(.CLK_HZ(TB_CLK_HZ)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .slot_cnt_i (slot_cnt_i),
    .buf_raddr_o(buf_raddr_o),
    .buf_rdata_i(buf_rdata_i),
    .line_o     (line_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    start_i = (idx == pulse_a) || (idx == pulse_b);
    idx++;
    @(negedge clk);
  endtask

  // one packet; samples every cycle at the falling edge
  task automatic run_pkt(input int n_cfg, input int n_after, input logic [7:0] seed,
                         input int pa, input int pb, input string tag);
    int n_eff, total, bad_act, bad_exp;
    bit bad;
    logic [7:0] byt;
    logic e;
    n_eff   = (n_cfg > 258) ? 258 : n_cfg;
    total   = 32 + (258 - n_eff) + 255;
    seed_q  = seed;
    pulse_a = pa;
    pulse_b = pb;
    slot_cnt_i = 9'(n_cfg);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    slot_cnt_i = 9'(n_after);
    idx = 0;
    // R2 break
    bad = 0; bad_act = 0;
    for (int i = 0; i < TB_BRK; i++) begin
      if (line_o !== 1'b0 || busy_o !== 1'b1) begin bad = 1; bad_act = {line_o, busy_o}; end
      step();
    end
    chk(!bad, "R2", {tag, " break {line,busy}"}, bad_act, 1);
    // R3 mark
    bad = 0; bad_act = 0;
    for (int i = 0; i < TB_MAB; i++) begin
      if (line_o !== 1'b1 || busy_o !== 1'b1) begin bad = 1; bad_act = {line_o, busy_o}; end
      step();
    end
    chk(!bad, "R3", {tag, " mark {line,busy}"}, bad_act, 3);
    // R4 R5 R6 characters
    for (int c = 0; c < total; c++) begin
      byt = (c < 32) ? pat(c, seed) : 8'h00;
      bad = 0; bad_act = 0; bad_exp = 0;
      for (int b = 0; b < 11; b++) begin
        if (b == 0)      e = 1'b0;
        else if (b < 9)  e = byt[b-1];
        else             e = 1'b1;
        for (int k = 0; k < TB_BIT; k++) begin
          if (!bad && (line_o !== e || busy_o !== 1'b1)) begin
            bad = 1; bad_act = {line_o, busy_o}; bad_exp = {e, 1'b1};
          end
          step();
        end
      end
      chk(!bad, (c < 32) ? "R5" : "R6",
          $sformatf("%s R4 char %0d byte %02h {line,busy}", tag, c, byt), bad_act, bad_exp);
    end
    // R10 end of packet
    chk(done_o === 1'b1 && busy_o === 1'b0 && line_o === 1'b1, "R10",
        {tag, " done/busy/line after last stop"}, {done_o, busy_o, line_o}, 5);
    step();
    chk(done_o === 1'b0, "R10", {tag, " done width"}, done_o, 0);
    chk(line_o === 1'b1 && busy_o === 1'b0, "R1", {tag, " idle after packet"},
        {line_o, busy_o}, 2);
    // R9 no second packet from an ignored start
    repeat (20) begin
      if (busy_o !== 1'b0) bad = 1;
      step();
    end
    chk(busy_o === 1'b0 && line_o === 1'b1, "R9", {tag, " stays idle"}, busy_o, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    start_i = 1'b0;
    slot_cnt_i = '0;
    seed_q = 8'h00;
    idx = 0;
    pulse_a = -1;
    pulse_b = -1;
    repeat (5) @(negedge clk);
    chk(line_o === 1'b1 && busy_o === 1'b0 && done_o === 1'b0, "R1", "reset state",
        {line_o, busy_o, done_o}, 4);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(line_o === 1'b1 && busy_o === 1'b0 && done_o === 1'b0, "R1", "idle after reset",
        {line_o, busy_o, done_o}, 4);

    // R6: full slot count, minimum padding
    run_pkt(258, 258, 8'h11, -1, -1, "R6 n258");
    // R6 R9: no slots, maximum padding; starts during break and data ignored
    run_pkt(0, 0, 8'hA7, 40, TB_BRK + TB_MAB + 3 * 11 * TB_BIT + 5, "R9 n0");
    // R8: above range clamps to 258
    run_pkt(300, 300, 8'h3C, -1, -1, "R8 n300");
    // R7: sampled 257, input changed to 0 after start
    run_pkt(257, 0, 8'hF0, -1, -1, "R7 n257");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (195_000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule